// File: doc/BRIEF.md
# Colour-Tagged Wrong-Path Discard Unit

This block sits between an instruction prefetcher and the execute stage of a pipeline in which the number of instructions in flight between fetch and execute is not fixed. A small colour value travels with every fetched packet. The execute side holds the colour it currently expects. A packet whose colour differs from the expected colour is consumed and dropped, and nothing else in the block changes. When the flow of control changes, the colour changes with it. Every packet that was prefetched down the old path then fails the match, however many of them are still in flight.

The colour is two bits wide. Bit 1 follows taken-branch redirects and bit 0 follows late data aborts, so each kind of flow change flips its own bit. Branch and abort redirects do not enter the packet path. They come in on two request/grant pairs and pass through a single arbiter. A redirect can therefore be granted while the packet path is stalled by back-pressure. After a grant, the block sends a one-cycle redirect with the target address back to the fetch PC and shows the new colour to the prefetcher.

Top module: `flow_colour_filter`

## Requirements
- R1: During and immediately after reset, `fetch_colour` is 2'b00, `redir_valid` is 0, and no grant is given while no request is raised.
- R2: A valid packet whose `in_colour` equals `fetch_colour` appears in the same cycle on `out_valid`/`out_data`, with `in_ready` equal to `out_ready`.
- R3: A valid packet whose `in_colour` differs from `fetch_colour` is accepted (`in_ready` 1) in the same cycle. `out_valid` stays 0 and `discard_pulse` is 1 for that cycle.
- R4: A branch grant inverts `fetch_colour[1]` at the next clock edge. An abort grant inverts `fetch_colour[0]` at the next clock edge. With no grant, the colour holds.
- R5: In the cycle after a grant, `redir_valid` is 1 for exactly one cycle and `redir_pc` holds the target of the granted requester.
- R6: At most one grant is given per cycle. When both requests are raised together, the abort request wins.
- R7: No grant is given in the cycle after a grant. A request that is not granted must be held, and it is granted in a later cycle.
- R8: With `in_valid` low, `out_valid` and `discard_pulse` are 0. `in_ready` follows `out_ready` when the colour matches and is 1 when it does not.
- R9: A redirect request is granted even while `out_ready` is 0.
- R10: In a stream with a branch at any point, no old-colour packet that arrives after the grant reaches the output, and every packet carrying the new colour reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched packet present |
| in_ready | output | 1 | Packet accepted (passed or dropped) |
| in_colour | input | 2 | Colour tag of the packet ({branch, abort}) |
| in_data | input | DATA_W | Packet payload |
| out_valid | output | 1 | Packet offered to execute |
| out_ready | input | 1 | Execute can take the packet |
| out_data | output | DATA_W | Payload to execute |
| br_req | input | 1 | Taken-branch redirect request |
| br_target | input | PC_W | Branch target address |
| br_gnt | output | 1 | Branch request granted this cycle |
| ab_req | input | 1 | Late-abort redirect request |
| ab_target | input | PC_W | Abort handler address |
| ab_gnt | output | 1 | Abort request granted this cycle |
| redir_valid | output | 1 | One-cycle redirect to the fetch PC |
| redir_pc | output | PC_W | New fetch address |
| fetch_colour | output | 2 | Current colour (fetch tag and execute expectation) |
| discard_pulse | output | 1 | A packet was dropped this cycle |

## Verification
A wrong colour register shows up in the very next cycle. Matching packets start to vanish with `discard_pulse` raised, or stale packets leak onto `out_valid`. `fetch_colour` also reports the wrong value one edge after the bad grant. An arbiter that fails to observe the one-cycle gap, or that picks the wrong winner, is visible on the grant pins in the same cycle. It is also visible one cycle later as a wrong `redir_pc` or a colour bit that inverted on the wrong side.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int CLR_W  = 2;   // one bit per flow-change source
  localparam int N_SRC  = 2;   // redirect requesters
  localparam int SRC_AB = 0;   // late abort: highest priority, colour bit 0
  localparam int SRC_BR = 1;   // taken branch, colour bit 1

  typedef logic [CLR_W-1:0] colour_t;
  typedef logic [N_SRC-1:0] src_vec_t;

  // Lowest index wins; result is one-hot or zero.
  function automatic src_vec_t first_set(input src_vec_t req);
    src_vec_t g;
    g = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) g = src_vec_t'(1) << i;
    end
    return g;
  endfunction

  function automatic logic stale_tag(input colour_t tag, input colour_t want);
    return tag != want;
  endfunction
endpackage

// File: rtl/cf_arbiter.sv
module cf_arbiter
  import cf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t req,
  output src_vec_t gnt
);
  logic gap_q;

  assign gnt = gap_q ? '0 : first_set(req);

  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= |gnt;
  end

  // R6
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R7
  grant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (gnt == '0));
  // R6
  abort_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req[SRC_AB] && req[SRC_BR] && (|gnt)) |-> gnt[SRC_AB]);
endmodule

// File: rtl/cf_colour_track.sv
module cf_colour_track
  import cf_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  src_vec_t        gnt,
  input  logic [PC_W-1:0] tgt [N_SRC],
  output colour_t         colour,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc
);
  colour_t         colour_q;
  logic            rv_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_sel;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      colour_q[i] <= 1'b0;
      else if (gnt[i]) colour_q[i] <= ~colour_q[i];
    end
    // R4
    bit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |=> (colour_q[i] != $past(colour_q[i])));
  end

  always_comb begin
    pc_sel = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (gnt[i]) pc_sel = tgt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      pc_q <= '0;
    end else begin
      rv_q <= |gnt;
      if (|gnt) pc_q <= pc_sel;
    end
  end

  assign colour      = colour_q;
  assign redir_valid = rv_q;
  assign redir_pc    = pc_q;

  // R4
  colour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> $stable(colour_q));
  // R5
  redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q);
endmodule

// File: rtl/cf_filter.sv
module cf_filter
  import cf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  colour_t           want,
  input  logic              in_valid,
  output logic              in_ready,
  input  colour_t           in_colour,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              drop
);
  logic wrong_path;

  assign wrong_path = stale_tag(in_colour, want);
  assign out_valid  = in_valid && !wrong_path;
  assign out_data   = in_data;
  assign in_ready   = wrong_path || out_ready;
  assign drop       = in_valid && wrong_path;

  // R3
  drop_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (in_ready && !out_valid));
  // R2
  pass_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_colour == want));
endmodule

// File: rtl/flow_colour_filter.sv
module flow_colour_filter
  import cf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_colour,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              br_req,
  input  logic [PC_W-1:0]   br_target,
  output logic              br_gnt,
  input  logic              ab_req,
  input  logic [PC_W-1:0]   ab_target,
  output logic              ab_gnt,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc,
  output logic [1:0]        fetch_colour,
  output logic              discard_pulse
);
  src_vec_t        req;
  src_vec_t        gnt;
  colour_t         cur_colour;
  logic [PC_W-1:0] tgt [N_SRC];

  assign req[SRC_AB] = ab_req;
  assign req[SRC_BR] = br_req;
  assign tgt[SRC_AB] = ab_target;
  assign tgt[SRC_BR] = br_target;

  cf_arbiter u_arb (
    .clk (clk),
    .rst_n (rst_n),
    .req (req),
    .gnt (gnt)
  );

  cf_colour_track #(.PC_W(PC_W)) u_trk (
    .clk (clk),
    .rst_n (rst_n),
    .gnt (gnt),
    .tgt (tgt),
    .colour (cur_colour),
    .redir_valid (redir_valid),
    .redir_pc (redir_pc)
  );

  cf_filter #(.DATA_W(DATA_W)) u_flt (
    .clk (clk),
    .rst_n (rst_n),
    .want (cur_colour),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_colour (in_colour),
    .in_data (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data (out_data),
    .drop (discard_pulse)
  );

  assign br_gnt       = gnt[SRC_BR];
  assign ab_gnt       = gnt[SRC_AB];
  assign fetch_colour = cur_colour;

  // R9
  gnt_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_req && !redir_valid) |-> ab_gnt);
  // R5
  redir_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_gnt || ab_gnt) |=> redir_valid);
endmodule

// File: tb/flow_colour_filter_tb.sv
module flow_colour_filter_tb;
  localparam int DW = 8;
  localparam int PW = 16;
  localparam logic [PW-1:0] BR_T = 16'h0100;
  localparam logic [PW-1:0] AB_T = 16'h0200;

  typedef struct packed {
    logic br, ab, iv;
    logic [1:0] col;
    logic ordy;
    logic [7:0] data;
    logic eov, eir, edis, ebg, eag, erv;
    logic [1:0] ecol;
    logic [15:0] epc;
  } vec_t;

  // br ab iv col ordy data | ov ir dis bg ag rv ecol epc
  localparam vec_t VT [12] = '{
    '{1'b0,1'b0,1'b1,2'b00,1'b1,8'h11, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,16'h0000}, // R2 pass
    '{1'b0,1'b0,1'b1,2'b00,1'b0,8'h12, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,16'h0000}, // R2 stall
    '{1'b0,1'b0,1'b1,2'b01,1'b0,8'h13, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,16'h0000}, // R3 drop
    '{1'b1,1'b0,1'b1,2'b00,1'b1,8'h14, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,16'h0000}, // R6 branch grant
    '{1'b0,1'b1,1'b1,2'b00,1'b1,8'h15, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,2'b10,BR_T},     // R7 gap, R5
    '{1'b0,1'b1,1'b1,2'b10,1'b1,8'h16, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'b10,BR_T},     // R7 held req
    '{1'b1,1'b1,1'b1,2'b10,1'b1,8'h17, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,AB_T},     // R4 abort bit
    '{1'b1,1'b1,1'b1,2'b11,1'b1,8'h18, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'b11,AB_T},     // R6 abort wins
    '{1'b1,1'b0,1'b1,2'b11,1'b1,8'h19, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,2'b10,AB_T},     // R7 gap
    '{1'b1,1'b0,1'b1,2'b10,1'b0,8'h1A, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'b10,AB_T},     // R9 stall grant
    '{1'b0,1'b0,1'b0,2'b01,1'b0,8'h1B, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'b00,BR_T},     // R8 idle
    '{1'b0,1'b0,1'b1,2'b00,1'b1,8'h1C, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,BR_T}      // R2 new path
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [1:0] in_colour = 2'b00, fetch_colour;
  logic [DW-1:0] in_data = '0, out_data;
  logic br_req = 1'b0, ab_req = 1'b0, br_gnt, ab_gnt, redir_valid, discard_pulse;
  logic [PW-1:0] redir_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flow_colour_filter #(.DATA_W(DW), .PC_W(PW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_colour (in_colour), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
    .br_req (br_req), .br_target (BR_T), .br_gnt (br_gnt),
    .ab_req (ab_req), .ab_target (AB_T), .ab_gnt (ab_gnt),
    .redir_valid (redir_valid), .redir_pc (redir_pc),
    .fetch_colour (fetch_colour), .discard_pulse (discard_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int k;
    int seen_new;
    int leaked;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    #3;
    chk("R1 colour in reset", 32'(fetch_colour), 32'h0);
    chk("R1 redir in reset", 32'(redir_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk("R1 colour after reset", 32'(fetch_colour), 32'h0);
    chk("R1 no grant idle", 32'({br_gnt, ab_gnt}), 32'h0);

    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      br_req = VT[v].br; ab_req = VT[v].ab; in_valid = VT[v].iv;
      in_colour = VT[v].col; out_ready = VT[v].ordy; in_data = VT[v].data;
      #3;
      chk("R2 out_valid", 32'(out_valid), 32'(VT[v].eov));
      if (VT[v].eov) chk("R2 out_data", 32'(out_data), 32'(VT[v].data));
      chk("R8 in_ready", 32'(in_ready), 32'(VT[v].eir));
      chk("R3 discard_pulse", 32'(discard_pulse), 32'(VT[v].edis));
      chk("R6 br_gnt", 32'(br_gnt), 32'(VT[v].ebg));
      chk("R6 ab_gnt", 32'(ab_gnt), 32'(VT[v].eag));
      chk("R5 redir_valid", 32'(redir_valid), 32'(VT[v].erv));
      if (VT[v].erv) chk("R5 redir_pc", 32'(redir_pc), 32'(VT[v].epc));
      chk("R4 fetch_colour", 32'(fetch_colour), 32'(VT[v].ecol));
    end

    // R10: branch at a random point in a stream, three stale packets in flight
    @(negedge clk);
    br_req = 1'b0; ab_req = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    k = 4 + int'($urandom_range(0, 12));
    seen_new = 0;
    leaked = 0;
    for (int p = 0; p < 30; p++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 8'(p);
      br_req = (p == k);
      in_colour = (p <= k + 3) ? 2'b00 : 2'b10;
      #3;
      if (p == k) chk("R10 branch granted mid-stream", 32'(br_gnt), 32'h1);
      if (p > k && p <= k + 3 && out_valid) leaked++;
      if (p > k + 3 && out_valid && out_data == 8'(p)) seen_new++;
      if (p <= k) chk("R10 pre-branch passes", 32'(out_valid), 32'h1);
    end
    chk("R10 stale leaked", 32'(leaked), 32'h0);
    chk("R10 new-colour delivered", 32'(seen_new), 32'(30 - (k + 4)));

    // R1: reset clears a toggled colour
    @(negedge clk);
    in_valid = 1'b0; br_req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk("R1 colour cleared", 32'(fetch_colour), 32'h0);
    chk("R1 redir cleared", 32'(redir_valid), 32'h0);
    finish_run();
  end
endmodule